// File: doc/BRIEF.md
# Page Access Protection Checker

This block screens every memory reference that the translation path is about to turn into a physical address. It runs beside the address computation and does not follow it. A reference is described by its page number, its access kind (read, write or execute) and the flag bits of the page-table entry it hits. It is checked against a length bound that gives how many pages the current process owns. One clock after the request strobe, the block reports either permission to proceed or a trap, together with a two-bit cause that the trap handler can decode.

Three checks run in parallel on every request: a bound compare of the page number against the length bound, a test of the entry's valid flag, and a permission test that matches the access kind against the entry's permission flags. A fixed priority turns the three results into a single cause. A parameter selects how permission is read from the flags. In the first variant, read, write and execute are each granted by their own bit, so any combination can be expressed. In the second variant, a single writable bit separates read-only pages from read-write pages, and read and execute are always granted.

Top module: `pgprot_check`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done_o`, `allow_o` and `trap_o` are low and `cause_o` is 0.
- R2: A request sampled on `req_i` at a rising edge produces `done_o` high for exactly the next cycle. In a cycle that follows an edge with `req_i` low, `done_o`, `allow_o` and `trap_o` are low and `cause_o` is 0. Requests on consecutive cycles give consecutive independent results.
- R3: A page number greater than or equal to `len_i` traps with cause 1. With `len_i` = 0 every page traps. With `len_i` = 2^PN_W no page traps for this reason.
- R4: A page inside the bound whose entry has flag bit 0 (valid) clear traps with cause 2, whatever the access kind or the permission bits.
- R5: A write (`acc_i` = 1) to a valid in-bound page whose flag bit 2 (write permission) is clear traps with cause 3.
- R6: With PERM_STYLE = 0, a read (`acc_i` = 0) needs flag bit 1 and an execute (`acc_i` = 2) needs flag bit 3. Each bit grants only its own access kind, in any combination. A missing bit traps with cause 3.
- R7: The reserved access code `acc_i` = 3 is never permitted. On a valid in-bound page it traps with cause 3.
- R8: When several checks fail, the cause is the first of: bound (1), then invalid (2), then permission (3).
- R9: `allow_o` is high with cause 0 exactly when a completed request passes all three checks. `allow_o` and `trap_o` are never high together.
- R10: With PERM_STYLE = 1, reads and executes on a valid in-bound page are allowed whatever flag bits 1 and 3 hold. Writes still require flag bit 2.
- R11: With 3-bit page numbers (a 14-bit address space in 2 KB pages) and `len_i` = 6, every address from 12288 to 16383 traps with cause 1, and address 10468 (page 5) is allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one check per cycle it is high |
| page_i | input | PN_W | Page number of the reference |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| flags_i | input | 4 | Entry flags: bit0 valid, bit1 read, bit2 write, bit3 execute |
| len_i | input | PN_W+1 | Number of pages owned by the process |
| done_o | output | 1 | Result valid, one cycle after the request |
| allow_o | output | 1 | Reference permitted |
| trap_o | output | 1 | Reference refused |
| cause_o | output | 2 | 0 allowed, 1 out of bound, 2 invalid entry, 3 permission |

## Verification
The bench builds two copies with PN_W = 3: one with independent permission bits (PERM_STYLE = 0) and one with the single writable bit (PERM_STYLE = 1). Both copies see the same stimulus. With only eight pages and a four-bit length value, the bench can reach both length extremes (0 and 8), each boundary page, and every combination of access kind and permission flags exhaustively. The same small page width is the worked 14-bit, 2 KB-page layout, so the address-level example can be checked directly.

// File: rtl/pgprot_pkg.sv
package pgprot_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_BOUND  = 2'd1,
      CAUSE_ABSENT = 2'd2,
      CAUSE_PERM   = 2'd3
   } cause_e;

   localparam int FLAG_W   = 4;
   localparam int FLAG_VLD = 0;
   localparam int FLAG_RD  = 1;
   localparam int FLAG_WR  = 2;
   localparam int FLAG_EX  = 3;

   localparam int STYLE_SPLIT = 0;
   localparam int STYLE_RO    = 1;

endpackage

// File: rtl/pgprot_bound.sv
module pgprot_bound #(
   parameter int PN_W  = 12,
   parameter int LEN_W = PN_W + 1
) (
   input  logic [PN_W-1:0]  page_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             in_range_o
);
   localparam int PAD_W = LEN_W - PN_W;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("pgprot_bound: LEN_W must exceed PN_W");
      end
   endgenerate

   logic [LEN_W-1:0] page_ext;

   assign page_ext   = {{PAD_W{1'b0}}, page_i};
   assign in_range_o = (page_ext < len_i);

endmodule

// File: rtl/pgprot_perm.sv
module pgprot_perm
   import pgprot_pkg::*;
#(
   parameter int PERM_STYLE = STYLE_SPLIT
) (
   input  logic [1:0] acc_i,
   input  logic       rd_i,
   input  logic       wr_i,
   input  logic       ex_i,
   output logic       permit_o
);
   generate
      if (PERM_STYLE == STYLE_SPLIT) begin : g_split
         always_comb begin
            case (acc_i)
               ACC_READ:  permit_o = rd_i;
               ACC_WRITE: permit_o = wr_i;
               ACC_EXEC:  permit_o = ex_i;
               default:   permit_o = 1'b0;
            endcase
         end
      end else if (PERM_STYLE == STYLE_RO) begin : g_ro
         logic unused_perm_bits;
         assign unused_perm_bits = rd_i ^ ex_i;
         always_comb begin
            case (acc_i)
               ACC_READ:  permit_o = 1'b1;
               ACC_WRITE: permit_o = wr_i;
               ACC_EXEC:  permit_o = 1'b1;
               default:   permit_o = 1'b0;
            endcase
         end
      end else begin : g_bad_style
         $error("pgprot_perm: PERM_STYLE must be 0 or 1");
         assign permit_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pgprot_prio.sv
module pgprot_prio
   import pgprot_pkg::*;
(
   input  logic       in_range_i,
   input  logic       valid_i,
   input  logic       permit_i,
   output logic [1:0] cause_o
);
   always_comb begin
      if (!in_range_i) begin
         cause_o = CAUSE_BOUND;
      end else if (!valid_i) begin
         cause_o = CAUSE_ABSENT;
      end else if (!permit_i) begin
         cause_o = CAUSE_PERM;
      end else begin
         cause_o = CAUSE_NONE;
      end
   end

endmodule

// File: rtl/pgprot_check.sv
module pgprot_check
   import pgprot_pkg::*;
#(
   parameter int PN_W       = 12,
   parameter int PERM_STYLE = STYLE_SPLIT
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic [PN_W-1:0] page_i,
   input  logic [1:0]      acc_i,
   input  logic [3:0]      flags_i,
   input  logic [PN_W:0]   len_i,
   output logic            done_o,
   output logic            allow_o,
   output logic            trap_o,
   output logic [1:0]      cause_o
);
   localparam int LEN_W = PN_W + 1;

   generate
      if (PN_W < 1 || PN_W > 32) begin : g_bad_pn
         $error("pgprot_check: PN_W out of range 1..32");
      end
      if (PERM_STYLE != STYLE_SPLIT && PERM_STYLE != STYLE_RO) begin : g_bad_style
         $error("pgprot_check: unknown PERM_STYLE");
      end
   endgenerate

   logic       in_range;
   logic       permit;
   logic [1:0] cause_d;

   logic       done_q;
   logic       allow_q;
   logic       trap_q;
   logic [1:0] cause_q;

   pgprot_bound #(
      .PN_W  (PN_W),
      .LEN_W (LEN_W)
   ) u_bound (
      .page_i     (page_i),
      .len_i      (len_i),
      .in_range_o (in_range)
   );

   pgprot_perm #(
      .PERM_STYLE (PERM_STYLE)
   ) u_perm (
      .acc_i    (acc_i),
      .rd_i     (flags_i[FLAG_RD]),
      .wr_i     (flags_i[FLAG_WR]),
      .ex_i     (flags_i[FLAG_EX]),
      .permit_o (permit)
   );

   pgprot_prio u_prio (
      .in_range_i (in_range),
      .valid_i    (flags_i[FLAG_VLD]),
      .permit_i   (permit),
      .cause_o    (cause_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         allow_q <= 1'b0;
         trap_q  <= 1'b0;
         cause_q <= CAUSE_NONE;
      end else if (req_i) begin
         done_q  <= 1'b1;
         allow_q <= (cause_d == CAUSE_NONE);
         trap_q  <= (cause_d != CAUSE_NONE);
         cause_q <= cause_d;
      end else begin
         done_q  <= 1'b0;
         allow_q <= 1'b0;
         trap_q  <= 1'b0;
         cause_q <= CAUSE_NONE;
      end
   end

   assign done_o  = done_q;
   assign allow_o = allow_q;
   assign trap_o  = trap_q;
   assign cause_o = cause_q;

endmodule

// File: rtl/pgprot_check_sva.sv
module pgprot_check_sva #(
   parameter int PN_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_i,
   input logic [PN_W-1:0] page_i,
   input logic [1:0]      acc_i,
   input logic [3:0]      flags_i,
   input logic [PN_W:0]   len_i,
   input logic            done_o,
   input logic            allow_o,
   input logic            trap_o,
   input logic [1:0]      cause_o
);
   logic out_of_bound;
   assign out_of_bound = ({1'b0, page_i} >= len_i);

   AST_RESULT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> done_o);                                              // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!done_o && !allow_o && !trap_o && cause_o == 2'd0)); // R2
   AST_BOUND_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && out_of_bound) |=> (trap_o && cause_o == 2'd1));        // R3
   AST_INVALID_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !out_of_bound && !flags_i[0]) |=> (trap_o && cause_o == 2'd2)); // R4
   AST_WRITE_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !out_of_bound && flags_i[0] && acc_i == 2'd1 && !flags_i[2])
      |=> (trap_o && cause_o == 2'd3));                               // R5
   AST_RSVD_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && acc_i == 2'd3) |=> trap_o);                            // R7
   AST_ALLOW_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(allow_o && trap_o));                                           // R9
   AST_ALLOW_CAUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      allow_o |-> (done_o && cause_o == 2'd0));                        // R9
   AST_TRAP_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (done_o && cause_o != 2'd0));                         // R8

endmodule

bind pgprot_check pgprot_check_sva #(
   .PN_W (PN_W)
) u_sva (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_i   (req_i),
   .page_i  (page_i),
   .acc_i   (acc_i),
   .flags_i (flags_i),
   .len_i   (len_i),
   .done_o  (done_o),
   .allow_o (allow_o),
   .trap_o  (trap_o),
   .cause_o (cause_o)
);

// File: tb/pgprot_check_tb_top.sv
module pgprot_check_tb_top;
   localparam int PN_W = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req = 1'b0;
   logic [PN_W-1:0] page = '0;
   logic [1:0]      acc = '0;
   logic [3:0]      flags = '0;
   logic [PN_W:0]   len = '0;

   logic       done_s, allow_s, trap_s;
   logic [1:0] cause_s;
   logic       done_r, allow_r, trap_r;
   logic [1:0] cause_r;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pgprot_check #(.PN_W(PN_W), .PERM_STYLE(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .page_i(page), .acc_i(acc),
      .flags_i(flags), .len_i(len), .done_o(done_s), .allow_o(allow_s),
      .trap_o(trap_s), .cause_o(cause_s));

   pgprot_check #(.PN_W(PN_W), .PERM_STYLE(1)) dut_ro_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .page_i(page), .acc_i(acc),
      .flags_i(flags), .len_i(len), .done_o(done_r), .allow_o(allow_r),
      .trap_o(trap_r), .cause_o(cause_r));

   function automatic int exp_cause(int style, int pg, int ac, logic [3:0] fl, int ln);
      bit ok;
      if (pg >= ln) return 1;
      if (!fl[0]) return 2;
      case (ac)
         0: ok = (style == 1) ? 1'b1 : fl[1];
         1: ok = fl[2];
         2: ok = (style == 1) ? 1'b1 : fl[3];
         default: ok = 1'b0;
      endcase
      return ok ? 0 : 3;
   endfunction

   task automatic cmp(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_out(string tag, int style, int e_done, int e_cause);
      int ea, et;
      ea = (e_done == 1 && e_cause == 0) ? 1 : 0;
      et = (e_done == 1 && e_cause != 0) ? 1 : 0;
      if (style == 0) begin
         cmp(tag, "split done", done_s, e_done);
         cmp(tag, "split allow", allow_s, ea);
         cmp(tag, "split trap", trap_s, et);
         cmp(tag, "split cause", cause_s, e_cause);
      end else begin
         cmp(tag, "ro done", done_r, e_done);
         cmp(tag, "ro allow", allow_r, ea);
         cmp(tag, "ro trap", trap_r, et);
         cmp(tag, "ro cause", cause_r, e_cause);
      end
   endtask

   // One request, result checked on the next negedge (one register stage).
   task automatic run_req(string tag, int pg, int ac, logic [3:0] fl, int ln);
      @(negedge clk);
      req = 1'b1; page = PN_W'(pg); acc = 2'(ac); flags = fl; len = (PN_W+1)'(ln);
      @(negedge clk);
      req = 1'b0;
      check_out(tag, 0, 1, exp_cause(0, pg, ac, fl, ln));
      check_out(tag, 1, 1, exp_cause(1, pg, ac, fl, ln));
   endtask

   task automatic t_reset();
      #1;
      check_out("R1 in reset", 0, 0, 0);
      check_out("R1 in reset", 1, 0, 0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1 after reset", 0, 0, 0);
      check_out("R1 after reset", 1, 0, 0);
   endtask

   task automatic t_idle_and_backtoback();
      run_req("R2 single", 2, 0, 4'b1111, 8);
      @(negedge clk);
      check_out("R2 idle", 0, 0, 0);
      check_out("R2 idle", 1, 0, 0);
      @(negedge clk);
      req = 1'b1; page = 3'd1; acc = 2'd1; flags = 4'b0011; len = 4'd8;
      @(negedge clk);
      check_out("R2 b2b first", 0, 1, 3);
      check_out("R2 b2b first", 1, 1, 3);
      page = 3'd1; acc = 2'd0; flags = 4'b0011;
      @(negedge clk);
      req = 1'b0;
      check_out("R2 b2b second", 0, 1, 0);
      check_out("R2 b2b second", 1, 1, 0);
   endtask

   task automatic t_bound();
      for (int p = 0; p < 8; p++) run_req("R3 len0", p, 0, 4'b1111, 0);
      for (int p = 0; p < 8; p++) run_req("R3 len8", p, 0, 4'b1111, 8);
      run_req("R3 edge below", 3, 0, 4'b1111, 4);
      run_req("R3 edge at", 4, 0, 4'b1111, 4);
      run_req("R3 edge above", 7, 2, 4'b1111, 4);
   endtask

   task automatic t_invalid();
      for (int a = 0; a < 4; a++) run_req("R4 invalid", 2, a, 4'b1110, 8);
      run_req("R4 invalid noperm", 0, 1, 4'b0000, 1);
   endtask

   task automatic t_perm_matrix();
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 8; b++)
            run_req("R5 R6 R7 R10 matrix", 5, a, {3'(b), 1'b1}, 8);
   endtask

   task automatic t_priority();
      run_req("R8 bound over invalid", 6, 1, 4'b0000, 6);
      run_req("R8 bound over perm", 7, 3, 4'b0001, 2);
      run_req("R8 invalid over perm", 1, 3, 4'b0000, 2);
      run_req("R9 all pass", 1, 2, 4'b1001, 2);
   endtask

   task automatic t_example();
      int addrs[4] = '{10468, 12287, 12288, 16383};
      foreach (addrs[i]) run_req("R11 address", addrs[i] >> 11, 0, 4'b1111, 6);
   endtask

   initial begin
      t_reset();
      t_idle_and_backtoback();
      t_bound();
      t_invalid();
      t_perm_matrix();
      t_priority();
      t_example();
      @(negedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule